// File: doc/BRIEF.md
# Rectifier Controller Mode Supervisor

This block is the operating-mode state machine of a secondary-side synchronous rectifier controller. It decides whether the gate sequencer may drive the rectifier switch. It takes two digitised supply comparisons (above the turn-on level, and below the lockout level) and an enable line. It also takes a flag that fires when the drain has swung above the positive re-arm level, and a per-cycle report from the gate sequencer that says whether the last conduction ended before the minimum on time. From these it produces a gate-permit signal, a two-bit mode code and a sleep indication.

The supervisor holds the controller in lockout until the supply is valid. It parks the controller in sleep whenever the qualified enable is low. Entry to normal operation is synchronised with the switching cycle: on entry, permission stays low until the first positive drain swing. Once the gate is permitted, a conduction cycle shorter than the minimum on time moves the block to a protection mode with the gate suppressed. The minimum-on-time check keeps running in that mode, and a long enough cycle restores normal operation. The enable line is synchronised, and its level is accepted only after it has been stable for a programmable number of clocks.

Top module: `sr_mode_supervisor`

## Requirements
- R1: After reset, and until the turn-on indication is seen, the mode code is 0 (lockout), gate permit is 0 and the sleep output is 0.
- R2: The supply is taken as valid from the turn-on indication until the lockout indication. While neither indication is asserted the supply state is held (hysteresis). The lockout indication returns the block to mode 0 from any mode and wins when both indications are asserted together.
- R3: With the supply valid and the qualified enable low, the mode code is 1 (sleep), the sleep output is 1 and gate permit is 0. Lockout takes precedence over sleep.
- R4: With the supply valid and the qualified enable high, the block enters mode 2 (normal) with gate permit 0. Cycle reports are ignored until the first re-arm flag. After that flag, gate permit is 1.
- R5: In mode 2 with the gate permitted, a cycle report with the short-conduction flag set moves the block to mode 3 (protection), and gate permit drops to 0.
- R6: In mode 3 a short cycle report keeps mode 3. A cycle report without the short flag returns the block to mode 2 with gate permit 1 and needs no new re-arm flag.
- R7: The enable input is synchronised, and a change of level is accepted only after the synchronised level has differed from the accepted one for EN_HI_CYC consecutive clocks (rising) or EN_LO_CYC consecutive clocks (falling). Shorter excursions have no effect on the mode.
- R8: Every pass through lockout or sleep clears the one-time activation. After each re-entry to mode 2, gate permit stays 0 until a new re-arm flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_above_on_i | input | 1 | Supply is above the turn-on level |
| vcc_below_off_i | input | 1 | Supply is below the lockout level |
| enable_i | input | 1 | Asynchronous enable line |
| drain_rearm_i | input | 1 | Drain has swung above the positive re-arm level |
| cycle_done_i | input | 1 | One-clock strobe at the end of a conduction cycle |
| cycle_short_i | input | 1 | Qualifies cycle_done_i: conduction was shorter than the minimum on time |
| gate_permit_o | output | 1 | Gate sequencer may drive the switch |
| mode_o | output | 2 | 0 lockout, 1 sleep, 2 normal, 3 protection |
| sleep_o | output | 1 | Sleep mode is active |

## Verification
The bench builds the block with EN_HI_CYC = 5 and EN_LO_CYC = 3 in place of the microsecond-scale defaults. With these values it can sweep every enable pulse width on both sides of both thresholds, and compute arithmetically whether each pulse should be accepted. The short filter windows also let it walk every mode transition, including the lockout-over-sleep priority and the re-arm clearing after both sleep and lockout, in a few hundred clocks.

// File: rtl/sr_mode_pkg.sv
package sr_mode_pkg;

    typedef enum logic [1:0] {
        MODE_LOCKOUT = 2'd0,
        MODE_SLEEP   = 2'd1,
        MODE_RUN     = 2'd2,
        MODE_GUARD   = 2'd3
    } op_mode_e;

    typedef struct packed {
        logic strobe;
        logic short_on;
    } cyc_rep_t;

    typedef struct packed {
        logic supply_ok;
        logic enabled;
    } cond_t;

    function automatic logic mode_is_active(op_mode_e m);
        return (m == MODE_RUN) || (m == MODE_GUARD);
    endfunction

    function automatic int cnt_width(int a, int b);
        int mx;
        mx = (a > b) ? a : b;
        return (mx < 2) ? 1 : $clog2(mx + 1);
    endfunction

endpackage

// File: rtl/sr_supply_track.sv
module sr_supply_track (
    input  logic clk,
    input  logic rst,
    input  logic above_on_i,
    input  logic below_off_i,
    output logic supply_ok_o
);
    logic ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q <= 1'b0;
        end else if (below_off_i) begin
            ok_q <= 1'b0;
        end else if (above_on_i) begin
            ok_q <= 1'b1;
        end
    end

    assign supply_ok_o = ok_q;

    AST_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!above_on_i && !below_off_i) |=> $stable(ok_q)); // R2
    AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (rst)
        below_off_i |=> !ok_q); // R2

endmodule

// File: rtl/sr_en_filter.sv
module sr_en_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int HI_CYC      = 2500,
    parameter int LO_CYC      = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o
);
    import sr_mode_pkg::*;

    localparam int CW = cnt_width(HI_CYC, LO_CYC);
    localparam logic [CW-1:0] HI_LIM = CW'(HI_CYC - 1);
    localparam logic [CW-1:0] LO_LIM = CW'(LO_CYC - 1);

    logic [SYNC_STAGES-1:0] sreg;
    logic                   synced;
    logic                   filt_q;
    logic [CW-1:0]          cnt_q;
    logic [CW-1:0]          lim;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sreg <= '0;
                else     sreg <= raw_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sreg <= '0;
                else     sreg <= {sreg[SYNC_STAGES-2:0], raw_i};
            end
        end
    endgenerate

    assign synced = sreg[SYNC_STAGES-1];
    assign lim    = filt_q ? LO_LIM : HI_LIM;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q <= 1'b0;
            cnt_q  <= '0;
        end else if (synced != filt_q) begin
            if (cnt_q >= lim) begin
                filt_q <= synced;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign level_o = filt_q;

    AST_FILT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (synced == filt_q) |=> $stable(filt_q)); // R7
    AST_FILT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> (filt_q == $past(synced))); // R7

endmodule

// File: rtl/sr_mode_fsm.sv
module sr_mode_fsm (
    input  logic                    clk,
    input  logic                    rst,
    input  sr_mode_pkg::cond_t      cond_i,
    input  logic                    rearm_i,
    input  sr_mode_pkg::cyc_rep_t   cyc_i,
    output sr_mode_pkg::op_mode_e   mode_o,
    output logic                    permit_o
);
    import sr_mode_pkg::*;

    op_mode_e state_q, state_n;
    logic     armed_q, armed_n;

    always_comb begin
        state_n = state_q;
        armed_n = armed_q;
        if (!cond_i.supply_ok) begin
            state_n = MODE_LOCKOUT;
            armed_n = 1'b0;
        end else if (!cond_i.enabled) begin
            state_n = MODE_SLEEP;
            armed_n = 1'b0;
        end else begin
            case (state_q)
                MODE_LOCKOUT, MODE_SLEEP: begin
                    state_n = MODE_RUN;
                    armed_n = 1'b0;
                end
                MODE_RUN: begin
                    if (!armed_q) begin
                        if (rearm_i) armed_n = 1'b1;
                    end else if (cyc_i.strobe && cyc_i.short_on) begin
                        state_n = MODE_GUARD;
                    end
                end
                MODE_GUARD: begin
                    if (cyc_i.strobe && !cyc_i.short_on) state_n = MODE_RUN;
                end
                default: state_n = MODE_LOCKOUT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_LOCKOUT;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_n;
            armed_q <= armed_n;
        end
    end

    assign mode_o   = state_q;
    assign permit_o = (state_q == MODE_RUN) && armed_q;

    AST_LOCKOUT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        !cond_i.supply_ok |=> (state_q == MODE_LOCKOUT && !permit_o)); // R2
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (cond_i.supply_ok && !cond_i.enabled) |=> (state_q == MODE_SLEEP && !permit_o)); // R3
    AST_ENTRY_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (!mode_is_active(state_q) && cond_i.supply_ok && cond_i.enabled) |=> !permit_o); // R8
    AST_PERMIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(permit_o) |-> ($past(rearm_i) || $past(cyc_i.strobe && !cyc_i.short_on))); // R4
    AST_SHORT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (permit_o && cyc_i.strobe && cyc_i.short_on) |=> (!permit_o)); // R5
    AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_GUARD && cond_i.supply_ok && cond_i.enabled && !cyc_i.strobe)
        |=> (state_q == MODE_GUARD)); // R6

endmodule

// File: rtl/sr_mode_supervisor.sv
module sr_mode_supervisor #(
    parameter int SYNC_STAGES = 2,
    parameter int EN_HI_CYC   = 2500,
    parameter int EN_LO_CYC   = 1250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vcc_above_on_i,
    input  logic       vcc_below_off_i,
    input  logic       enable_i,
    input  logic       drain_rearm_i,
    input  logic       cycle_done_i,
    input  logic       cycle_short_i,
    output logic       gate_permit_o,
    output logic [1:0] mode_o,
    output logic       sleep_o
);
    import sr_mode_pkg::*;

    cond_t    cond;
    cyc_rep_t rep;
    op_mode_e mode;

    sr_supply_track u_supply (
        .clk         (clk),
        .rst         (rst),
        .above_on_i  (vcc_above_on_i),
        .below_off_i (vcc_below_off_i),
        .supply_ok_o (cond.supply_ok)
    );

    sr_en_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .HI_CYC      (EN_HI_CYC),
        .LO_CYC      (EN_LO_CYC)
    ) u_enable (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (enable_i),
        .level_o (cond.enabled)
    );

    assign rep.strobe   = cycle_done_i;
    assign rep.short_on = cycle_short_i;

    sr_mode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cond_i   (cond),
        .rearm_i  (drain_rearm_i),
        .cyc_i    (rep),
        .mode_o   (mode),
        .permit_o (gate_permit_o)
    );

    assign mode_o  = mode;
    assign sleep_o = (mode == MODE_SLEEP);

    AST_SLEEP_FLAG: assert property (@(posedge clk) disable iff (rst)
        sleep_o |-> !gate_permit_o); // R3
    AST_PERMIT_MODE: assert property (@(posedge clk) disable iff (rst)
        gate_permit_o |-> (mode_o == 2'd2)); // R5

endmodule

// File: tb/sr_mode_supervisor_tb.sv
module sr_mode_supervisor_tb_top;
    localparam int HI = 5;
    localparam int LO = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic above_on = 1'b0, below_off = 1'b0, en = 1'b0;
    logic rearm = 1'b0, cdone = 1'b0, cshort = 1'b0;
    logic permit, sleep;
    logic [1:0] mode;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [3:0] seen;

    always #4 clk = ~clk;

    sr_mode_supervisor #(.SYNC_STAGES(2), .EN_HI_CYC(HI), .EN_LO_CYC(LO)) dut_i (
        .clk(clk), .rst(rst),
        .vcc_above_on_i(above_on), .vcc_below_off_i(below_off),
        .enable_i(en), .drain_rearm_i(rearm),
        .cycle_done_i(cdone), .cycle_short_i(cshort),
        .gate_permit_o(permit), .mode_o(mode), .sleep_o(sleep)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic watch(int n);
        repeat (n) begin
            @(negedge clk);
            seen[mode] = 1'b1;
        end
    endtask

    task automatic pulse_rearm();
        rearm = 1'b1; @(negedge clk); rearm = 1'b0; @(negedge clk);
    endtask

    task automatic report(logic s);
        cdone = 1'b1; cshort = s; @(negedge clk);
        cdone = 1'b0; cshort = 1'b0; @(negedge clk);
    endtask

    task automatic supply(logic on_v, logic off_v);
        above_on = on_v; below_off = off_v; @(negedge clk);
        above_on = 1'b0; below_off = 1'b0; repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset mode", mode, 0);
        check("R1 reset permit", permit, 0);
        check("R1 reset sleep", sleep, 0);

        en = 1'b1; repeat (20) @(negedge clk);
        check("R1 no turn-on yet", mode, 0);

        // both indications at once: lockout wins
        supply(1'b1, 1'b1);
        check("R2 both indications", mode, 0);

        supply(1'b1, 1'b0);
        repeat (10) @(negedge clk);
        check("R2 supply held valid", mode, 2);
        check("R4 entry unarmed", permit, 0);
        report(1'b1);
        check("R4 unarmed report ignored", mode, 2);
        pulse_rearm();
        check("R4 armed permit", permit, 1);

        report(1'b0);
        check("R5 long cycle stays normal", mode, 2);
        report(1'b1);
        check("R5 short enters protection", mode, 3);
        check("R5 permit dropped", permit, 0);
        report(1'b1);
        check("R6 short keeps protection", mode, 3);
        report(1'b0);
        check("R6 long restores normal", mode, 2);
        check("R6 permit restored", permit, 1);

        // low pulse sweep in normal mode
        for (int w = 1; w <= LO + 3; w++) begin
            seen = '0;
            en = 1'b0; watch(w);
            en = 1'b1; watch(HI + LO + 12);
            check($sformatf("R7 low pulse w=%0d sleep seen", w), int'(seen[1]), (w >= LO) ? 1 : 0);
            check($sformatf("R7 low pulse w=%0d mode", w), mode, 2);
            if (w >= LO) begin
                check($sformatf("R8 rearm cleared after sleep w=%0d", w), permit, 0);
                pulse_rearm();
            end
            check($sformatf("R7 permit after w=%0d", w), permit, 1);
        end

        // enter sleep
        en = 1'b0; repeat (LO + 6) @(negedge clk);
        check("R3 sleep mode", mode, 1);
        check("R3 sleep output", sleep, 1);
        check("R3 sleep permit", permit, 0);

        // high pulse sweep from sleep
        for (int w = 1; w <= HI + 3; w++) begin
            seen = '0;
            en = 1'b1; watch(w);
            en = 1'b0; watch(HI + LO + 12);
            check($sformatf("R7 high pulse w=%0d run seen", w), int'(seen[2]), (w >= HI) ? 1 : 0);
            check($sformatf("R7 high pulse w=%0d mode", w), mode, 1);
        end

        // lockout priority over sleep
        supply(1'b0, 1'b1);
        check("R3 lockout over sleep", mode, 0);
        check("R3 lockout sleep flag", sleep, 0);

        // back to normal, then lockout from protection
        en = 1'b1; repeat (HI + 6) @(negedge clk);
        check("R2 stays lockout without turn-on", mode, 0);
        supply(1'b1, 1'b0);
        check("R8 normal after lockout", mode, 2);
        pulse_rearm();
        report(1'b1);
        check("R5 protection again", mode, 3);
        supply(1'b0, 1'b1);
        check("R2 lockout from protection", mode, 0);
        check("R2 lockout permit", permit, 0);
        supply(1'b1, 1'b0);
        check("R8 rearm cleared after lockout", permit, 0);
        check("R8 mode normal", mode, 2);
        pulse_rearm();
        check("R8 rearmed", permit, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule